// File: doc/BRIEF.md
# Two-Queue Merge Select Unit

This block is one stage of a merge-based sorting pipeline. Upstream logic pushes two ascending runs of `RUN_LEN` words into a pair of queues. When both queues of the selected pair are full, the block streams out one ascending run of `2*RUN_LEN` words. On every accepted output beat it takes the smaller of the two queue heads and removes it.

There are two such pairs. The pair that is not being merged can be filled while the other one drains, so filling and merging overlap. When one run of the active pair is used up, the rest of the other run is passed through without any comparison. A push that would corrupt data is dropped and flagged. Such a push either targets the pair under merge or lands on a full queue.

Several of these stages can be chained, each one doubling the run length of the previous one.

Top module: `merge_select_unit`

## Requirements
- R1: After a synchronous active-low reset, `out_valid`, `out_last` and `ovf_err` are 0, all four queues are empty, and pair 0 is the active pair.
- R2: A merge starts only when both queues of the active pair hold exactly `RUN_LEN` words. `out_valid` rises on the clock edge after the one at which this condition is first seen.
- R3: A push is dropped when it targets the active pair while a merge is running, or when it targets a queue that already holds `RUN_LEN` words. `ovf_err` is 1 in the cycle after each dropped push and 0 after each accepted or absent push.
- R4: While both runs still have words left, `out_data` is the head of the first run (`in_side`=0) if that head is strictly smaller than the head of the second run (`in_side`=1). Otherwise it is the head of the second run, so ties go to the second run. The comparison is unsigned.
- R5: Once every word of one run has been output, the remaining words of the other run are output in queue order, whatever their values.
- R6: Every merge outputs exactly `2*RUN_LEN` words. `out_last` is 1 on the final word only, and `out_valid` is 0 in the cycle after that word is accepted.
- R7: While `out_valid` is 1 and `out_ready` is 0, nothing is removed from the queues, and `out_valid` and `out_data` hold their values in the next cycle.
- R8: Merges alternate between pair 0 and pair 1. Pushes to the pair that is not active are accepted while the other pair is being merged.
- R9: Given ascending input runs, the words of one merge come out in non-decreasing order.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Push strobe for one word |
| in_pair | input | 1 | Target queue pair (0 or 1) |
| in_side | input | 1 | Target run in the pair: 0 = first run, 1 = second run |
| in_data | input | DATA_W | Word being pushed |
| out_valid | output | 1 | A merged word is present |
| out_ready | input | 1 | Downstream accepts the word this cycle |
| out_data | output | DATA_W | Merged word |
| out_last | output | 1 | Final word of the current merge |
| ovf_err | output | 1 | Previous cycle's push was dropped |

## Verification
The embedded properties check the following on every cycle:
- the queues never overrun or underrun;
- during a merge, the remaining counts agree with the occupancy of the active queues;
- a merge starts only from two full queues;
- a stalled output holds steady;
- the active pair toggles after the last word;
- accepted words never decrease within a merge.

Some behaviour can only be shown by the bench's scenarios against its queue-based model:
- the tie rule;
- the pass-through drain once a run is exhausted, in either direction;
- overlapped filling of the idle pair;
- the two different causes of a dropped push under a random ready pattern.

// File: rtl/msu_pkg.sv
// Package: shared state encoding and run-side indices for the merge select unit.
package msu_pkg;
    typedef enum logic {
        MS_IDLE = 1'b0,
        MS_RUN  = 1'b1
    } msu_state_e;

    localparam int SIDE_FIRST  = 0;
    localparam int SIDE_SECOND = 1;
endpackage

// File: rtl/msu_fifo.sv
// msu_fifo: single-clock queue of DEPTH words with a combinational head.
// Assumes the owner never pushes when full or pops when empty (checked below).
module msu_fifo #(
    parameter int W     = 16,
    parameter int DEPTH = 8,
    localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push,
    input  logic [W-1:0]  push_data,
    input  logic          pop,
    output logic [W-1:0]  head,
    output logic [CW-1:0] count,
    output logic          full
);
    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wr_ptr;
    logic [AW-1:0] rd_ptr;
    logic [CW-1:0] cnt;

    // Storage write; contents need no reset.
    always_ff @(posedge clk) begin
        if (push) mem[wr_ptr] <= push_data;
    end

    // Pointer and occupancy update with wrap at DEPTH-1.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            cnt    <= '0;
        end else begin
            if (push) wr_ptr <= (wr_ptr == AW'(DEPTH - 1)) ? '0 : wr_ptr + AW'(1);
            if (pop)  rd_ptr <= (rd_ptr == AW'(DEPTH - 1)) ? '0 : rd_ptr + AW'(1);
            cnt <= cnt + CW'(push) - CW'(pop);
        end
    end

    assign head  = mem[rd_ptr];
    assign count = cnt;
    assign full  = (cnt == CW'(DEPTH));

    // R3: dropped pushes never reach a full queue.
    p_no_overrun_r3: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> (cnt != CW'(DEPTH)));

    // R5: draining never reads an empty queue.
    p_no_underrun_r5: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> (cnt != '0));
endmodule

// File: rtl/msu_pick.sv
// msu_pick: chooses which run supplies the next output word.
// It takes the first run on a strict less-than, otherwise the second; an exhausted run is never chosen.
module msu_pick #(
    parameter int W  = 16,
    parameter int CW = 4
) (
    input  logic [W-1:0]  head_a,
    input  logic [W-1:0]  head_b,
    input  logic [CW-1:0] rem_a,
    input  logic [CW-1:0] rem_b,
    output logic          take_a
);
    // Exhaustion overrides the value compare.
    always_comb begin
        if (rem_b == '0)      take_a = 1'b1;
        else if (rem_a == '0) take_a = 1'b0;
        else                  take_a = (head_a < head_b);
    end
endmodule

// File: rtl/msu_merge_ctrl.sv
// msu_merge_ctrl: merge sequencer for the active pair.
// It starts when both queues of the active pair are full, counts down the words left in each run,
// pops one head per accepted beat, then hands over to the other pair.
// Assumes the top blocks pushes into the active pair while a merge runs.
module msu_merge_ctrl
    import msu_pkg::*;
#(
    parameter int W       = 16,
    parameter int RUN_LEN = 8,
    localparam int CW     = $clog2(RUN_LEN + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [CW-1:0] cnt_a,
    input  logic [CW-1:0] cnt_b,
    input  logic [W-1:0]  head_a,
    input  logic [W-1:0]  head_b,
    input  logic          out_ready,
    output logic          act_pair,
    output logic          pop_a,
    output logic          pop_b,
    output logic          out_valid,
    output logic [W-1:0]  out_data,
    output logic          out_last
);
    msu_state_e    state;
    logic          act;
    logic [CW-1:0] rem_a;
    logic [CW-1:0] rem_b;
    logic          take_a;
    logic          start;
    logic          fire;
    logic          final_word;

    msu_pick #(.W(W), .CW(CW)) pick_i (
        .head_a (head_a),
        .head_b (head_b),
        .rem_a  (rem_a),
        .rem_b  (rem_b),
        .take_a (take_a)
    );

    // Start, beat and last-word conditions.
    always_comb begin
        start      = (state == MS_IDLE) && (cnt_a == CW'(RUN_LEN)) && (cnt_b == CW'(RUN_LEN));
        fire       = (state == MS_RUN) && out_ready;
        final_word = ((rem_a == CW'(1)) && (rem_b == '0)) ||
                     ((rem_a == '0) && (rem_b == CW'(1)));
    end

    // Sequencer state, remaining counts and pair toggle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= MS_IDLE;
            act   <= 1'b0;
            rem_a <= '0;
            rem_b <= '0;
        end else if (start) begin
            state <= MS_RUN;
            rem_a <= CW'(RUN_LEN);
            rem_b <= CW'(RUN_LEN);
        end else if (fire) begin
            if (take_a) rem_a <= rem_a - CW'(1);
            else        rem_b <= rem_b - CW'(1);
            if (final_word) begin
                state <= MS_IDLE;
                act   <= ~act;
            end
        end
    end

    assign act_pair  = act;
    assign pop_a     = fire && take_a;
    assign pop_b     = fire && !take_a;
    assign out_valid = (state == MS_RUN);
    assign out_data  = take_a ? head_a : head_b;
    assign out_last  = out_valid && final_word;

    // R2: a merge begins only from two full queues.
    p_start_full_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(out_valid) |-> (cnt_a == CW'(RUN_LEN)) && (cnt_b == CW'(RUN_LEN)));

    // R6: remaining counts track the queue occupancy during a merge.
    p_rem_track_r6: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (cnt_a == rem_a) && (cnt_b == rem_b));

    // R6: the merge closes right after its last word.
    p_last_closes_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_ready && out_last) |=> !out_valid);

    // R8: the active pair swaps after each completed merge.
    p_pair_swap_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_ready && out_last) |=> (act_pair != $past(act_pair)));

    // R9: accepted words never decrease within one merge.
    p_ascend_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_ready && !out_last) |=> out_valid && (out_data >= $past(out_data)));
endmodule

// File: rtl/merge_select_unit.sv
// merge_select_unit: two ping-pong queue pairs feeding one streaming two-way merge.
// Pushes go to the queue chosen by in_pair/in_side. A push that would disturb the merging pair
// or overfill a queue is dropped and flagged on ovf_err one cycle later.
// Assumes each pushed run is ascending and RUN_LEN words long.
module merge_select_unit #(
    parameter int DATA_W  = 16,
    parameter int RUN_LEN = 8,
    localparam int CW     = $clog2(RUN_LEN + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic              in_pair,
    input  logic              in_side,
    input  logic [DATA_W-1:0] in_data,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [DATA_W-1:0] out_data,
    output logic              out_last,
    output logic              ovf_err
);
    logic [DATA_W-1:0] head_q [2][2];
    logic [CW-1:0]     cnt_q  [2][2];
    logic              full_q [2][2];
    logic              act_pair;
    logic              pop_a;
    logic              pop_b;
    logic              blocked;
    logic              err_q;

    // Drop rule: the pair under merge, or a full target queue.
    always_comb begin
        blocked = (out_valid && (in_pair == act_pair)) || full_q[in_pair][in_side];
    end

    for (genvar gp = 0; gp < 2; gp++) begin : g_pair
        for (genvar gs = 0; gs < 2; gs++) begin : g_side
            logic q_push;
            logic q_pop;
            assign q_push = in_valid && !blocked && (in_pair == 1'(gp)) && (in_side == 1'(gs));
            assign q_pop  = (act_pair == 1'(gp)) && ((gs == msu_pkg::SIDE_FIRST) ? pop_a : pop_b);
            msu_fifo #(.W(DATA_W), .DEPTH(RUN_LEN)) fifo_i (
                .clk       (clk),
                .rst_n     (rst_n),
                .push      (q_push),
                .push_data (in_data),
                .pop       (q_pop),
                .head      (head_q[gp][gs]),
                .count     (cnt_q[gp][gs]),
                .full      (full_q[gp][gs])
            );
        end
    end

    msu_merge_ctrl #(.W(DATA_W), .RUN_LEN(RUN_LEN)) ctrl_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .cnt_a     (cnt_q[act_pair][msu_pkg::SIDE_FIRST]),
        .cnt_b     (cnt_q[act_pair][msu_pkg::SIDE_SECOND]),
        .head_a    (head_q[act_pair][msu_pkg::SIDE_FIRST]),
        .head_b    (head_q[act_pair][msu_pkg::SIDE_SECOND]),
        .out_ready (out_ready),
        .act_pair  (act_pair),
        .pop_a     (pop_a),
        .pop_b     (pop_b),
        .out_valid (out_valid),
        .out_data  (out_data),
        .out_last  (out_last)
    );

    // Error flag for the previous cycle's dropped push.
    always_ff @(posedge clk) begin
        if (!rst_n) err_q <= 1'b0;
        else        err_q <= in_valid && blocked;
    end

    assign ovf_err = err_q;

    // R7: a stalled beat holds its word.
    p_stall_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> out_valid && $stable(out_data));

    // R3: a push aimed at the merging pair is always flagged.
    p_merge_push_flag_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && in_valid && (in_pair == act_pair)) |=> ovf_err);
endmodule

// File: tb/merge_select_unit_tb.sv
`timescale 1ns/1ps
module merge_select_unit_tb_top;
    localparam int W = 16;
    localparam int N = 8;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         in_valid = 1'b0;
    logic         in_pair = 1'b0;
    logic         in_side = 1'b0;
    logic [W-1:0] in_data = '0;
    logic         out_ready = 1'b1;
    logic         out_valid;
    logic [W-1:0] out_data;
    logic         out_last;
    logic         ovf_err;

    always #10 clk = ~clk;

    merge_select_unit #(.DATA_W(W), .RUN_LEN(N)) dut_i (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_pair(in_pair),
        .in_side(in_side), .in_data(in_data), .out_valid(out_valid),
        .out_ready(out_ready), .out_data(out_data), .out_last(out_last),
        .ovf_err(ovf_err)
    );

    int nvec = 0;
    int nmis = 0;
    bit cmp_on = 1'b0;
    bit rdy_rand = 1'b0;
    bit rdy_fixed = 1'b1;
    bit finished = 1'b0;

    // Behavioural reference: four queues, remaining counts, active pair.
    logic [W-1:0] qa0[$], qa1[$], qb0[$], qb1[$];
    bit m_merg, m_act, m_err;
    int m_ra, m_rb;

    function automatic int qsize(bit p, bit s);
        case ({p, s})
            2'b00: return qa0.size();
            2'b01: return qb0.size();
            2'b10: return qa1.size();
            default: return qb1.size();
        endcase
    endfunction

    function automatic logic [W-1:0] qhead(bit p, bit s);
        if (qsize(p, s) == 0) return '0;
        case ({p, s})
            2'b00: return qa0[0];
            2'b01: return qb0[0];
            2'b10: return qa1[0];
            default: return qb1[0];
        endcase
    endfunction

    task automatic qpop(bit p, bit s);
        case ({p, s})
            2'b00: void'(qa0.pop_front());
            2'b01: void'(qb0.pop_front());
            2'b10: void'(qa1.pop_front());
            default: void'(qb1.pop_front());
        endcase
    endtask

    task automatic qpush(bit p, bit s, logic [W-1:0] d);
        case ({p, s})
            2'b00: qa0.push_back(d);
            2'b01: qb0.push_back(d);
            2'b10: qa1.push_back(d);
            default: qb1.push_back(d);
        endcase
    endtask

    function automatic bit m_take_first();
        if (m_rb == 0) return 1'b1;
        if (m_ra == 0) return 1'b0;
        return qhead(m_act, 1'b0) < qhead(m_act, 1'b1);
    endfunction

    // Model update on each rising edge from the pre-edge state.
    always @(posedge clk) begin
        bit blk;
        bit st;
        bit tk;
        if (!rst_n) begin
            qa0.delete(); qa1.delete(); qb0.delete(); qb1.delete();
            m_merg = 0; m_act = 0; m_err = 0; m_ra = 0; m_rb = 0;
        end else begin
            blk = (m_merg && (in_pair == m_act)) || (qsize(in_pair, in_side) == N);
            m_err = in_valid && blk;
            st = !m_merg && (qsize(m_act, 0) == N) && (qsize(m_act, 1) == N);
            if (m_merg && out_ready) begin
                tk = m_take_first();
                qpop(m_act, !tk);
                if (tk) m_ra--; else m_rb--;
                if (m_ra + m_rb == 0) begin
                    m_merg = 0;
                    m_act = !m_act;
                end
            end else if (st) begin
                m_merg = 1; m_ra = N; m_rb = N;
            end
            if (in_valid && !blk) qpush(in_pair, in_side, in_data);
        end
    end

    task automatic check(input string req, input string what,
                         input logic [31:0] got, input logic [31:0] exp);
        nvec++;
        if (got !== exp) begin
            nmis++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, got, exp);
        end
    endtask

    // Per-cycle comparison, stall hold and per-merge checks, sampled at the falling edge.
    bit prev_v = 0, prev_r = 0;
    logic [W-1:0] prev_d = '0;
    logic [W-1:0] runq[$];
    int runs_seen = 0;
    always @(negedge clk) begin
        bit tk;
        if (cmp_on && !finished) begin
            check("R2", "out_valid", 32'(out_valid), 32'(m_merg));
            check("R3", "ovf_err", 32'(ovf_err), 32'(m_err));
            if (m_merg) begin
                tk = m_take_first();
                check((m_ra == 0 || m_rb == 0) ? "R5" : "R4", "out_data",
                      32'(out_data), 32'(qhead(m_act, !tk)));
                check("R6", "out_last", 32'(out_last), 32'(m_ra + m_rb == 1));
            end
            if (prev_v && !prev_r) begin
                check("R7", "held valid", 32'(out_valid), 32'd1);
                check("R7", "held data", 32'(out_data), 32'(prev_d));
            end
            if (out_valid && out_ready) begin
                runq.push_back(out_data);
                if (out_last) begin
                    runs_seen++;
                    check("R6", "words per merge", 32'(runq.size()), 32'(2 * N));
                    for (int i = 1; i < runq.size(); i++)
                        if (runq[i] < runq[i-1])
                            check("R9", "ascending order", 32'(runq[i]), 32'(runq[i-1]));
                    nvec++;
                    runq.delete();
                end
            end
            prev_v = out_valid;
            prev_r = out_ready;
            prev_d = out_data;
        end
    end

    task automatic cyc(bit v, bit p, bit s, logic [W-1:0] d);
        @(negedge clk);
        in_valid = v; in_pair = p; in_side = s; in_data = d;
        out_ready = rdy_rand ? (($urandom % 3) != 0) : rdy_fixed;
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) cyc(0, 0, 0, '0);
    endtask

    task automatic fill(bit p, int a0, int as, int b0, int bs);
        for (int i = 0; i < N; i++) begin
            cyc(1, p, 0, W'(a0 + i * as));
            cyc(1, p, 1, W'(b0 + i * bs));
        end
    endtask

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nmis);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            nmis++;
            $display("FAIL watchdog: actual timeout expected completion");
            summary();
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state at the ports.
        check("R1", "out_valid after reset", 32'(out_valid), 32'd0);
        check("R1", "ovf_err after reset", 32'(ovf_err), 32'd0);
        check("R1", "out_last after reset", 32'(out_last), 32'd0);
        cmp_on = 1;
        // R2/R4: fill pair 0 with interleaved runs that include ties.
        fill(0, 1, 3, 1, 2);
        // R3: push to pair 0 while it is full or merging is dropped.
        cyc(1, 0, 0, 16'd999);
        // R8 and R5: fill pair 1 during the merge; the first run drains before the second.
        fill(1, 0, 1, 100, 1);
        // R7: random backpressure while pair 1 merges.
        rdy_rand = 1;
        idle(80);
        rdy_rand = 0;
        // R4: all-equal runs take the second run first.
        fill(0, 5, 0, 5, 0);
        idle(40);
        // R3: ninth push into a full queue; R5: second run exhausted first.
        for (int i = 0; i < N; i++) cyc(1, 1, 0, W'(200 + i));
        cyc(1, 1, 0, 16'd300);
        rdy_fixed = 0;
        for (int i = 0; i < N; i++) cyc(1, 1, 1, W'(2 * i));
        idle(10);
        rdy_fixed = 1;
        idle(40);
        // R8: four merges completed, alternating pairs.
        check("R8", "merges completed", 32'(runs_seen), 32'd4);
        finished = 1;
        summary();
        $finish;
    end
endmodule